// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block divides the peripheral clock down to the 16x oversampling tick that a UART transmitter and receiver share. Software writes one divider word; the block extracts a 15-bit field from it, treats the upper 13 bits as a whole count and the lower 2 bits as quarters, and adds one implicit whole count. The division factor is therefore 1 + field/4 clock cycles per tick. A factor of 1 gives a bit rate of the clock divided by 16. The largest field gives a bit rate near the clock divided by 16 times 8192.

Each tick interval is either the whole part of the factor or one cycle longer. A 2-bit phase accumulator picks between the two, so any four consecutive intervals add up to exactly four times the factor. A write to the divider word restarts the interval count and clears the accumulator. The first tick after a write therefore falls at a known cycle.

Top module: `baud_frac_div`

## Requirements
- R1: The divider field is taken from `cfg_wdata[20:6]`. Bits 20:8 are the whole part W and bits 7:6 are the quarter part Q. Bits 5:0 and 31:21 have no effect on the tick timing.
- R2: Every tick interval, measured in clock cycles from one tick to the next, is either W+1 or W+2. It is W+2 exactly when the accumulator carries (R3).
- R3: A 2-bit accumulator A is cleared by reset and by every write. On each tick, A+Q is formed; if it reaches 4, that interval is the long one and A takes the value (A+Q) mod 4. As a result, each group of four intervals after a write spans 4W+4+Q cycles. For Q=1 the interval pattern is short, short, short, long; for Q=2 it is short, long, short, long; for Q=3 it is short, long, long, long.
- R4: After reset the field is zero, so `tick` is high in every clock cycle from the first rising edge after reset is released.
- R5: A write sampled at rising edge E holds `tick` low after E. The first tick appears after edge E plus the first interval of the R3 pattern.
- R6: When W is nonzero, `tick` is a single-cycle pulse.
- R7: The largest field, W=8191 and Q=3, gives intervals of 8192 followed by 8193 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Divider word write strobe |
| cfg_wdata | input | 32 | Divider word |
| tick | output | 1 | 16x oversampling tick, registered |

## Verification
The tick is registered, so a write sampled at edge E affects `tick` from edge E onward. The bench drives the write at a falling edge and confirms at the next falling edge that `tick` is low. It then counts falling edges until each tick, so every measured interval starts from the previous observed tick. The expected intervals come from a model of the accumulator that runs in the bench. One interval too many or too few therefore shows up as a miscompare at that exact tick. The reset check samples `tick` at each falling edge after release, because R4 puts a tick after every rising edge.

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int DW     = 32,
  parameter int FLD_LO = 6,
  parameter int FRAC_W = 2,
  parameter int INT_W  = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_wdata,
  output logic          tick
);
  localparam int FLD_W = INT_W + FRAC_W;
  localparam int CW    = INT_W + 1;

  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic [CW-1:0]     cnt_q;
  logic [FLD_W-1:0]  fld;
  logic [FRAC_W:0]   sum;
  logic              hit;

  assign fld = cfg_wdata[FLD_LO +: FLD_W];
  assign sum = {1'b0, acc_q} + {1'b0, frac_q};
  assign hit = (cnt_q == ({1'b0, int_q} + CW'(sum[FRAC_W])));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      tick   <= 1'b0;
    end else if (cfg_we) begin
      int_q  <= fld[FLD_W-1:FRAC_W];
      frac_q <= fld[FRAC_W-1:0];
      acc_q  <= '0;
      cnt_q  <= '0;
      tick   <= 1'b0;
    end else if (hit) begin
      acc_q  <= sum[FRAC_W-1:0];
      cnt_q  <= '0;
      tick   <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick   <= 1'b0;
    end
  end
endmodule

module baud_frac_div_chk #(
  parameter int INT_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             tick,
  input logic [INT_W-1:0] int_q,
  input logic [INT_W:0]   cnt_q
);
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !tick);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && int_q != '0 && !cfg_we) |=> !tick);

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ({1'b0, int_q} + 1'b1));

  p_unity_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q == '0 && !cfg_we && !tick) |=> tick || $past(cfg_we));
endmodule

bind baud_frac_div baud_frac_div_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .tick(tick),
  .int_q(int_q), .cnt_q(cnt_q)
);

// File: tb/baud_frac_div_test.sv
module baud_frac_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        tick;
  int          n_chk = 0;
  int          n_err = 0;
  longint      cyc = 0;

  baud_frac_div uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .tick(tick)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 180000) begin
      n_err = n_err + 1;
      $display("FAIL watchdog: run hung, got %0d cycles, expected < 180000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_wdata = d;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R5 tick low after write", tick, 0);
  endtask

  // Writes d and checks n intervals against the accumulator model (R1, R2, R3, R5)
  task automatic run_pattern(input logic [31:0] d, input int n, input string req);
    int w, q, a, s, exp, gap;
    w = int'(d[20:8]);
    q = int'(d[7:6]);
    a = 0;
    wr(d);
    for (int i = 0; i < n; i++) begin
      s = a + q;
      exp = w + 1 + ((s >= 4) ? 1 : 0);
      a = s % 4;
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!tick && gap < 9000);
      check(req, gap, exp);
    end
  endtask

  task automatic t_reset;
    check("R4 tick low in reset", tick, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R4 tick every cycle after reset", tick, 1);
    end
  endtask

  task automatic t_group_sum(input logic [31:0] d);
    int gap, tot;
    wr(d);
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!tick && gap < 9000);
      tot += gap;
    end
    check("R3 four intervals sum", tot, 4 * int'(d[20:8]) + 4 + int'(d[7:6]));
  endtask

  task automatic t_pulse_width;
    int gap;
    wr(32'h0000_0500);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick && gap < 100);
    @(negedge clk);
    check("R6 tick single cycle", tick, 0);
  endtask

  task automatic t_restart;
    wr(32'h0000_0A00);
    repeat (7) @(negedge clk);
    run_pattern(32'h0000_0380, 4, "R5 restart mid interval");
  endtask

  initial begin
    t_reset();
    run_pattern(32'h0000_0200, 4, "R2 whole only W=2");
    run_pattern(32'h0000_0440, 8, "R3 Q=1 pattern");
    run_pattern(32'h0000_0380, 8, "R3 Q=2 pattern");
    run_pattern(32'h0000_05C0, 8, "R3 Q=3 pattern");
    run_pattern(32'h0000_0040, 8, "R3 W=0 Q=1 pattern");
    run_pattern(32'hFFE0_05FF, 8, "R1 ignored bits set");
    run_pattern(32'h0000_05C0 | 32'h0000_003F, 4, "R1 low bits ignored");
    t_group_sum(32'h0000_0AC0);
    t_pulse_width();
    t_restart();
    run_pattern(32'h001F_FFC0, 2, "R7 largest divider");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule